// File: doc/BRIEF.md
# Acknowledged Output Port Handshake

This block is a single 8-bit output channel that talks to an external device with a two-wire, active-low handshake. When the processor writes a byte, the byte is held on the port pins, the buffer-full line to the device goes low, and any pending interrupt request is withdrawn. The device pulls its acknowledge line low once it has taken the byte, and that releases the buffer-full line. When the device lets acknowledge go high again, the channel records that it wants another byte. It raises its interrupt request only when that record is set and the interrupt enable is on.

The interrupt enable has no register of its own. It is written with single-bit commands aimed at one position of the eight-bit port C, and the handshake state is read back as a port C status byte. The CHANNEL_B parameter picks the bit layout. With the default (0), the buffer-full flag sits at bit 7, the enable at bit 6 and the request at bit 3. With 1, the buffer-full flag sits at bit 1, the enable at bit 2 and the request at bit 0.

The acknowledge input comes from another clock domain, so it passes through a synchronizer before the edge detection sees it.

Top module: `ack_out_port`

## Requirements
- R1: After reset, obf_n is 1, intr is 0, port_data is 0, the interrupt enable is 0 and the status byte shows only obf_n (0x80 for the default layout).
- R2: When wr_en is high at a clock edge, port_data takes wr_data at that edge. It holds that value until the next write.
- R3: A write drives obf_n low and intr low at the same edge. This also holds when the buffer was already full, in which case the new byte replaces the old one.
- R4: If ack_n is first sampled low at edge k while obf_n is low and no write occurs, obf_n goes high at edge k+2. A low acknowledge while obf_n is already high changes nothing.
- R5: If ack_n is first sampled high at edge k after being low, and obf_n is high just before edge k+2, a request becomes pending at edge k+2. If obf_n is low at that point, no request becomes pending.
- R6: intr is high exactly when a request is pending and the enable is 1. Clearing the enable drops intr at the edge where the command lands. Setting the enable raises intr for a request that is already pending.
- R7: When bsr_wr is high, bsr_val is written into the enable if bsr_sel equals the enable position (6 by default, 2 for channel B). A command to any other position leaves the enable and all outputs unchanged.
- R8: A write in the same cycle as a detected acknowledge rise wins: obf_n goes low and no request becomes pending.
- R9: With the default layout, status is {obf_n, enable, 0, 0, intr, 0, 0, 0} from bit 7 down to bit 0. With channel B, status bit 2 is the enable, bit 1 is obf_n and bit 0 is intr, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle data write strobe from the processor |
| wr_data | input | 8 | Byte to send |
| bsr_wr | input | 1 | Single-bit port C command strobe |
| bsr_sel | input | 3 | Port C bit position addressed by the command |
| bsr_val | input | 1 | Value written to the addressed bit |
| ack_n | input | 1 | Active-low acknowledge from the device (asynchronous) |
| port_data | output | 8 | Latched byte driven to the device |
| obf_n | output | 1 | Active-low buffer-full flag to the device |
| intr | output | 1 | Interrupt request to the processor |
| status | output | 8 | Port C status byte |

## Verification
The checker watches every cycle for four things: the effect of a write on obf_n and intr, the release of obf_n after a detected acknowledge fall, the rule that intr never rises without both the enable and an empty buffer, and that data, buffer flag and enable stay stable when nothing addresses them. Some behaviour depends on the acknowledge delay, so only the bench scenarios can show it. These scenarios cover the exact two-cycle synchronizer latency, a request that stays pending while the enable is off, the write-versus-acknowledge collision, and bit commands aimed at neighbouring positions. The bench's behavioural model also covers these on every clock.

// File: rtl/aop_pkg.sv
package aop_pkg;

  localparam int unsigned PC_W = 8;

  function automatic logic [2:0] pos_obf(input logic chan_b);
    return chan_b ? 3'd1 : 3'd7;
  endfunction

  function automatic logic [2:0] pos_ien(input logic chan_b);
    return chan_b ? 3'd2 : 3'd6;
  endfunction

  function automatic logic [2:0] pos_intr(input logic chan_b);
    return chan_b ? 3'd0 : 3'd3;
  endfunction

  function automatic logic [PC_W-1:0] pack_status(input logic chan_b,
                                                  input logic obf_n,
                                                  input logic ien,
                                                  input logic intr);
    logic [PC_W-1:0] s;
    s = '0;
    s[pos_obf(chan_b)]  = obf_n;
    s[pos_ien(chan_b)]  = ien;
    s[pos_intr(chan_b)] = intr;
    return s;
  endfunction

endpackage

// File: rtl/aop_sync.sv
module aop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/aop_handshake.sv
module aop_handshake #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_s,
  output logic [DATA_W-1:0] data_q,
  output logic              obf_n,
  output logic              pend_q,
  output logic              ack_fall_ev,
  output logic              ack_rise_ev
);
  logic ack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_d <= 1'b1;
    else        ack_d <= ack_s;
  end

  assign ack_fall_ev = ack_d & ~ack_s;
  assign ack_rise_ev = ~ack_d & ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (wr_en) data_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_n  <= 1'b1;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      obf_n  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ack_fall_ev) obf_n <= 1'b1;
      if (ack_rise_ev && obf_n) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/aop_ctrl_bits.sv
module aop_ctrl_bits #(
  parameter logic [2:0] IEN_POS = 3'd6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bsr_wr,
  input  logic [2:0] bsr_sel,
  input  logic       bsr_val,
  output logic       ien_q
);
  logic hit;
  assign hit = bsr_wr && (bsr_sel == IEN_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ien_q <= 1'b0;
    else if (hit) ien_q <= bsr_val;
  end
endmodule

// File: rtl/ack_out_port.sv
module ack_out_port
  import aop_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        CHANNEL_B   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bsr_wr,
  input  logic [2:0]        bsr_sel,
  input  logic              bsr_val,
  input  logic              ack_n,
  output logic [DATA_W-1:0] port_data,
  output logic              obf_n,
  output logic              intr,
  output logic [PC_W-1:0]   status
);
  localparam logic [2:0] IEN_POS = pos_ien(CHANNEL_B);

  logic ack_s;
  logic pend_q;
  logic ien_q;
  logic ack_fall_ev;
  logic ack_rise_ev;

  aop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ack_n), .dout(ack_s)
  );

  aop_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ack_s(ack_s), .data_q(port_data), .obf_n(obf_n), .pend_q(pend_q),
    .ack_fall_ev(ack_fall_ev), .ack_rise_ev(ack_rise_ev)
  );

  aop_ctrl_bits #(.IEN_POS(IEN_POS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bsr_wr(bsr_wr), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .ien_q(ien_q)
  );

  assign intr   = pend_q & ien_q;
  assign status = pack_status(CHANNEL_B, obf_n, ien_q, intr);
endmodule

// File: rtl/ack_out_port_checker.sv
module ack_out_port_checker #(
  parameter int unsigned DATA_W  = 8,
  parameter logic [2:0]  IEN_POS = 3'd6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              bsr_wr,
  input logic [2:0]        bsr_sel,
  input logic              obf_n,
  input logic              intr,
  input logic [DATA_W-1:0] port_data,
  input logic              ien,
  input logic              ack_fall_ev
);
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !obf_n);
  a_r3_write_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !intr);
  a_r4_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall_ev && !wr_en) |=> obf_n);
  a_r4_obf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ack_fall_ev) |=> $stable(obf_n));
  a_r6_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ien);
  a_r5_req_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> obf_n);
  a_r2_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(port_data));
  a_r7_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsr_wr && bsr_sel == IEN_POS) |=> $stable(ien));
endmodule

bind ack_out_port ack_out_port_checker #(.DATA_W(DATA_W), .IEN_POS(IEN_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bsr_wr(bsr_wr), .bsr_sel(bsr_sel),
  .obf_n(obf_n), .intr(intr), .port_data(port_data), .ien(ien_q),
  .ack_fall_ev(ack_fall_ev)
);

// File: tb/ack_out_port_bench.sv
module ack_out_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bsr_wr = 1'b0;
  logic [2:0] bsr_sel = 3'd0;
  logic       bsr_val = 1'b0;
  logic       ack_n = 1'b1;
  logic [7:0] port_data;
  logic       obf_n;
  logic       intr;
  logic [7:0] status;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ack_out_port u_ack_out_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val), .ack_n(ack_n),
    .port_data(port_data), .obf_n(obf_n), .intr(intr), .status(status)
  );

  // behavioural reference: ack samples kept newest first
  bit   ack_hist[$];
  bit   m_obf = 1'b1;
  bit   m_pend = 1'b0;
  bit   m_ien = 1'b0;
  int   m_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_hist = '{1'b1, 1'b1, 1'b1};
      m_obf = 1'b1; m_pend = 1'b0; m_ien = 1'b0; m_data = 0;
    end else begin
      bit seen_low;
      bit seen_high;
      bit obf_before;
      seen_low   = ack_hist[2] && !ack_hist[1];
      seen_high  = !ack_hist[2] && ack_hist[1];
      obf_before = m_obf;
      if (wr_en) begin
        m_data = wr_data; m_obf = 1'b0; m_pend = 1'b0;
      end else begin
        if (seen_low) m_obf = 1'b1;
        if (seen_high && obf_before) m_pend = 1'b1;
      end
      if (bsr_wr && bsr_sel == 3'd6) m_ien = bsr_val;
      ack_hist.push_front(ack_n);
      void'(ack_hist.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_status();
    int s;
    s = 0;
    if (m_obf) s += 128;
    if (m_ien) s += 64;
    if (m_pend && m_ien) s += 8;
    return s;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 port_data", port_data, m_data);
      chk("R3/R4 obf_n", obf_n, m_obf);
      chk("R5/R6 intr", intr, m_pend && m_ien);
      chk("R9 status", status, exp_status());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bit_cmd(input logic [2:0] sel, input logic v);
    @(negedge clk); bsr_wr = 1'b1; bsr_sel = sel; bsr_val = v;
    @(negedge clk); bsr_wr = 1'b0;
  endtask

  task automatic ack_pulse(input int low_cycles);
    @(negedge clk); ack_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 obf_n", obf_n, 1);
    chk("R1 intr", intr, 0);
    chk("R1 port_data", port_data, 0);
    chk("R1 status", status, 8'h80);

    // R2/R3 write fills the buffer
    cpu_write(8'hA5);
    chk("R2 data", port_data, 8'hA5);
    chk("R3 obf low", obf_n, 0);

    // R4 exact latency: ack low sampled at edge k, obf high after k+2
    @(negedge clk); ack_n = 1'b0;
    @(negedge clk); chk("R4 still full at k", obf_n, 0);
    @(negedge clk); chk("R4 still full at k+1", obf_n, 0);
    @(negedge clk); chk("R4 released at k+2", obf_n, 1);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 pending but enable off
    chk("R6 masked intr", intr, 0);
    chk("R9 status masked", status, 8'h80);

    // R7 commands to other positions do nothing
    bit_cmd(3'd7, 1'b1);
    bit_cmd(3'd3, 1'b1);
    bit_cmd(3'd2, 1'b1);
    chk("R7 other bits ignored", status, 8'h80);
    // R6 enabling shows pending request
    bit_cmd(3'd6, 1'b1);
    chk("R6 intr after enable", intr, 1);
    chk("R9 status full set", status, 8'hC8);
    bit_cmd(3'd6, 1'b0);
    chk("R6 intr dropped", intr, 0);
    bit_cmd(3'd6, 1'b1);

    // R3 write clears request; overwrite while full
    cpu_write(8'h3C);
    chk("R3 intr cleared", intr, 0);
    cpu_write(8'hC3);
    chk("R3 overwrite data", port_data, 8'hC3);
    chk("R3 overwrite obf", obf_n, 0);

    // R5 write between ack fall and rise: no request
    @(negedge clk); ack_n = 1'b0;
    repeat (4) @(negedge clk);
    cpu_write(8'h11);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 no req when full", intr, 0);
    chk("R5 obf stays low", obf_n, 0);

    // R4 ack while empty no effect; fill then release
    ack_pulse(2);
    chk("R5 intr after ack", intr, 1);
    ack_pulse(3);
    chk("R4 idle ack no change", obf_n, 1);

    // R8 write collides with detected ack rise
    cpu_write(8'h77);
    @(negedge clk); ack_n = 1'b0;
    repeat (4) @(negedge clk);
    ack_n = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h99;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 collision intr", intr, 0);
    chk("R8 collision obf", obf_n, 0);
    chk("R8 collision data", port_data, 8'h99);

    // short single-cycle ack pulse
    ack_pulse(1);
    chk("R5 short pulse intr", intr, 1);
    chk("R9 final status", status, 8'hC8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule